// File: doc/BRIEF.md
# Reset and Oscillator Start-up Sequencer

This block keeps a small microcontroller core in reset until its clock source has had time to settle. Four reset causes feed it: a power-on request, a power-edge detector request, an active-low master-clear pin and a watchdog timeout. Whichever cause is active, the core stays in reset. Once every cause has gone away, the block counts a configured number of pulses on a free-running reference tick and then lets the core run.

Two static option inputs choose the oscillator kind and the requested start-up delay. Slower oscillators need more settling time, so some short delays are illegal for them. An illegal request is raised to the shortest delay that the chosen oscillator allows. An option input selects which power source is honoured: either the power-on request or the power-edge detector request, never both. On release, the block gives a one-cycle request to load the top program address as the reset vector. It also keeps a sticky flag recording that the last reset came from a power event.

Top module: `clkstart_reset_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `core_rst` is 1, `start_done` is 0, `vec_load` is 0 and `power_loss` is 0.
- R2: Delay codes on `dly_sel` are 0 = shortest (about 150 µs), 1 = 20 ms, 2 = 40 ms and 3 = 80 ms. With `osc_kind` = 0 (RC), every code is used as given. The core is released on the clock edge that takes in the Nth `tick` pulse after all causes clear, where N is the tick-count parameter of the code in use.
- R3: With `osc_kind` = 1 (fast crystal) or 2 (standard crystal), code 0 is replaced by code 1, and codes 1 to 3 are used as given.
- R4: With `osc_kind` = 3 (slow crystal), codes 0 and 1 are replaced by code 2, and codes 2 and 3 are used as given.
- R5: `pwr_on_req` causes a reset only while `edge_det_en` = 0. `pwr_edge_req` causes a reset only while `edge_det_en` = 1. A request that is not honoured leaves `start_done` and `power_loss` unchanged.
- R6: While `mclr_n` is low, `core_rst` is held at 1. After `mclr_n` rises, the tick count restarts from zero.
- R7: A one-cycle `wdog_expire` pulse puts `core_rst` at 1 two cycles later, and the full start-up delay is then counted again.
- R8: `power_loss` is set to 1 by an honoured power-on or power-edge reset. Master-clear and watchdog resets leave it unchanged. Only `rst` clears it.
- R9: `vec_load` is high for exactly the one cycle in which `start_done` first reads 1. `vec_addr` is always all ones, the last program address (0x1FF for 9 bits).
- R10: The core is never released on a cycle without a `tick` pulse. Without ticks, `core_rst` stays 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block initialisation |
| tick | input | 1 | One-cycle reference pulse that paces the delay |
| osc_kind | input | 2 | Oscillator kind option (0 RC, 1 fast crystal, 2 standard crystal, 3 slow crystal) |
| dly_sel | input | 2 | Requested start-up delay code |
| edge_det_en | input | 1 | Option: 1 selects the power-edge detector in place of power-on reset |
| pwr_on_req | input | 1 | Power-on reset request, active high |
| pwr_edge_req | input | 1 | Power-edge detector reset request, active high |
| mclr_n | input | 1 | Master-clear pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog timeout, active high |
| core_rst | output | 1 | Reset to the core, active high |
| start_done | output | 1 | Start-up delay complete, core running |
| vec_load | output | 1 | One-cycle request to load the reset vector |
| vec_addr | output | ADDR_W | Reset vector, all ones |
| power_loss | output | 1 | Sticky power-event reset flag |

## Verification
The delay path is driven with every RC delay code and with illegal codes on each crystal kind. The number of tick pulses needed for release then shows whether a code was kept or raised, and to which legal code. The tick parameters are scaled to distinct small values, so a wrong table entry or an off-by-one in the count shows up as release one tick early or late. Each reset cause is applied while the core is running, and the resulting `core_rst` and `power_loss` separate honoured from ignored sources and power events from the others. Long stretches with no tick pulses confirm that time alone never releases the core.

// File: rtl/clkstart_pkg.sv
package clkstart_pkg;

    typedef enum logic [1:0] {
        OSC_RC        = 2'd0,
        OSC_FAST_XTAL = 2'd1,
        OSC_STD_XTAL  = 2'd2,
        OSC_SLOW_XTAL = 2'd3
    } osc_kind_e;

    typedef enum logic [1:0] {
        DLY_SHORT = 2'd0,
        DLY_20MS  = 2'd1,
        DLY_40MS  = 2'd2,
        DLY_80MS  = 2'd3
    } dly_code_e;

    typedef enum logic [1:0] {
        SQ_HOLD  = 2'd0,
        SQ_COUNT = 2'd1,
        SQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic pwr_on;
        logic pwr_edge;
        logic ext_clr;
        logic wdog;
    } rst_cause_t;

    localparam int unsigned NUM_CODES = 4;

    // Shortest delay code that a given oscillator kind tolerates.
    function automatic dly_code_e floor_code(input osc_kind_e kind);
        dly_code_e f;
        case (kind)
            OSC_RC:        f = DLY_SHORT;
            OSC_FAST_XTAL: f = DLY_20MS;
            OSC_STD_XTAL:  f = DLY_20MS;
            default:       f = DLY_40MS;
        endcase
        return f;
    endfunction

    // Requested code, raised to the floor when it is too short.
    function automatic dly_code_e legal_code(input osc_kind_e kind, input dly_code_e req);
        dly_code_e f;
        f = floor_code(kind);
        return (req < f) ? f : req;
    endfunction

    function automatic logic cause_any(input rst_cause_t c);
        return c.pwr_on | c.pwr_edge | c.ext_clr | c.wdog;
    endfunction

    function automatic logic cause_is_power(input rst_cause_t c);
        return c.pwr_on | c.pwr_edge;
    endfunction

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rst_cause_collect.sv
module rst_cause_collect
    import clkstart_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_on_req,
    input  logic       pwr_edge_req,
    input  logic       edge_det_en,
    input  logic       mclr_n,
    input  logic       wdog_expire,
    output rst_cause_t cause_q
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   clr_pin_sync;
    rst_cause_t             cause_d;

    // Master-clear pin arrives asynchronously: bring it through a flop chain.
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= mclr_n;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], mclr_n};
            end
        end
    endgenerate

    assign clr_pin_sync = sync_q[SYNC_STAGES-1];

    // Exactly one of the two power sources is honoured, picked by the option.
    always_comb begin
        cause_d.pwr_on   = pwr_on_req   & ~edge_det_en;
        cause_d.pwr_edge = pwr_edge_req &  edge_det_en;
        cause_d.ext_clr  = ~clr_pin_sync;
        cause_d.wdog     = wdog_expire;
    end

    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= cause_d;
    end

endmodule

// File: rtl/delay_select.sv
module delay_select
    import clkstart_pkg::*;
#(
    parameter int unsigned TICKS_C0 = 3,
    parameter int unsigned TICKS_C1 = 400,
    parameter int unsigned TICKS_C2 = 800,
    parameter int unsigned TICKS_C3 = 1600,
    parameter int unsigned CW       = 11
) (
    input  logic [1:0]    osc_kind,
    input  logic [1:0]    dly_sel,
    output logic [CW-1:0] target_ticks
);

    logic [CW-1:0] tick_tbl [NUM_CODES];
    dly_code_e     use_code;

    // One table entry per delay code, each taken from its own parameter.
    generate
        for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_tbl
            localparam int unsigned TV = (gi == 0) ? TICKS_C0 :
                                         (gi == 1) ? TICKS_C1 :
                                         (gi == 2) ? TICKS_C2 : TICKS_C3;
            assign tick_tbl[gi] = CW'(TV);
        end
    endgenerate

    always_comb begin
        use_code     = legal_code(osc_kind_e'(osc_kind), dly_code_e'(dly_sel));
        target_ticks = tick_tbl[use_code];
    end

endmodule

// File: rtl/startup_timer.sv
module startup_timer
    import clkstart_pkg::*;
#(
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          tick,
    input  logic [CW-1:0] target_ticks,
    output logic          running,
    output logic          release_pulse
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;
    logic          rel_d;
    logic          rel_q;

    assign cnt_inc = cnt_q + CW'(1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rel_d   = 1'b0;
        case (state_q)
            SQ_HOLD: begin
                cnt_d = '0;
                state_d = SQ_COUNT;
            end
            SQ_COUNT: begin
                if (tick) begin
                    if (cnt_inc >= target_ticks) begin
                        state_d = SQ_RUN;
                        cnt_d   = '0;
                        rel_d   = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            SQ_RUN: ;
            default: begin
                state_d = SQ_HOLD;
                cnt_d   = '0;
            end
        endcase
        // Any active cause wins over the count and restarts it from zero.
        if (hold) begin
            state_d = SQ_HOLD;
            cnt_d   = '0;
            rel_d   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_HOLD;
            cnt_q   <= '0;
            rel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rel_q   <= rel_d;
        end
    end

    assign running       = (state_q == SQ_RUN);
    assign release_pulse = rel_q;

endmodule

// File: rtl/clkstart_reset_seq.sv
module clkstart_reset_seq
    import clkstart_pkg::*;
#(
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TICKS_C0    = 3,
    parameter int unsigned TICKS_C1    = 400,
    parameter int unsigned TICKS_C2    = 800,
    parameter int unsigned TICKS_C3    = 1600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        osc_kind,
    input  logic [1:0]        dly_sel,
    input  logic              edge_det_en,
    input  logic              pwr_on_req,
    input  logic              pwr_edge_req,
    input  logic              mclr_n,
    input  logic              wdog_expire,
    output logic              core_rst,
    output logic              start_done,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              power_loss
);

    localparam int unsigned MAX_TICKS = max_of4(TICKS_C0, TICKS_C1, TICKS_C2, TICKS_C3);
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    rst_cause_t    cause_q;
    logic [CW-1:0] target_ticks;
    logic          running;
    logic          rel_pulse;
    logic          plf_q;

    rst_cause_collect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_causes (
        .clk          (clk),
        .rst          (rst),
        .pwr_on_req   (pwr_on_req),
        .pwr_edge_req (pwr_edge_req),
        .edge_det_en  (edge_det_en),
        .mclr_n       (mclr_n),
        .wdog_expire  (wdog_expire),
        .cause_q      (cause_q)
    );

    delay_select #(
        .TICKS_C0 (TICKS_C0),
        .TICKS_C1 (TICKS_C1),
        .TICKS_C2 (TICKS_C2),
        .TICKS_C3 (TICKS_C3),
        .CW       (CW)
    ) u_dsel (
        .osc_kind     (osc_kind),
        .dly_sel      (dly_sel),
        .target_ticks (target_ticks)
    );

    startup_timer #(
        .CW (CW)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .hold          (cause_any(cause_q)),
        .tick          (tick),
        .target_ticks  (target_ticks),
        .running       (running),
        .release_pulse (rel_pulse)
    );

    // Sticky flag: only power events set it, only block init clears it.
    always_ff @(posedge clk) begin
        if (rst)                          plf_q <= 1'b0;
        else if (cause_is_power(cause_q)) plf_q <= 1'b1;
    end

    assign core_rst   = ~running;
    assign start_done = running;
    assign vec_load   = rel_pulse;
    assign vec_addr   = {ADDR_W{1'b1}};
    assign power_loss = plf_q;

endmodule

// File: rtl/clkstart_chk.sv
module clkstart_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic wdog_expire,
    input logic core_rst,
    input logic start_done,
    input logic vec_load,
    input logic power_loss
);

    // R7
    wdog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_expire |-> ##2 core_rst);

    // R10
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (core_rst && !tick) |=> core_rst);

    // R9
    vec_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(start_done) |-> vec_load);

    // R9
    vec_only_release_chk: assert property (@(posedge clk) disable iff (rst)
        vec_load |-> $rose(start_done));

    // R8
    plf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(power_loss));

endmodule

bind clkstart_reset_seq clkstart_chk u_clkstart_chk (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .wdog_expire (wdog_expire),
    .core_rst    (core_rst),
    .start_done  (start_done),
    .vec_load    (vec_load),
    .power_loss  (power_loss)
);

// File: tb/test_clkstart_reset_seq.sv
`timescale 1ns/1ps
module test_clkstart_reset_seq;

    localparam int unsigned AW = 9;
    localparam int unsigned T0 = 2;
    localparam int unsigned T1 = 4;
    localparam int unsigned T2 = 6;
    localparam int unsigned T3 = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [1:0]    osc_kind = 2'd0;
    logic [1:0]    dly_sel = 2'd0;
    logic          edge_det_en = 1'b0;
    logic          pwr_on_req = 1'b0;
    logic          pwr_edge_req = 1'b0;
    logic          mclr_n = 1'b1;
    logic          wdog_expire = 1'b0;
    logic          core_rst;
    logic          start_done;
    logic          vec_load;
    logic [AW-1:0] vec_addr;
    logic          power_loss;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    clkstart_reset_seq #(
        .ADDR_W   (AW),
        .TICKS_C0 (T0),
        .TICKS_C1 (T1),
        .TICKS_C2 (T2),
        .TICKS_C3 (T3)
    ) i_clkstart_reset_seq (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .osc_kind     (osc_kind),
        .dly_sel      (dly_sel),
        .edge_det_en  (edge_det_en),
        .pwr_on_req   (pwr_on_req),
        .pwr_edge_req (pwr_edge_req),
        .mclr_n       (mclr_n),
        .wdog_expire  (wdog_expire),
        .core_rst     (core_rst),
        .start_done   (start_done),
        .vec_load     (vec_load),
        .vec_addr     (vec_addr),
        .power_loss   (power_loss)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected ticks, worked out from the delay-code rules on their own.
    function automatic int exp_ticks(input int osc, input int sel);
        int floor_sel;
        int use_sel;
        if (osc == 0)      floor_sel = 0;
        else if (osc == 3) floor_sel = 2;
        else               floor_sel = 1;
        use_sel = (sel < floor_sel) ? floor_sel : sel;
        case (use_sel)
            0: return T0;
            1: return T1;
            2: return T2;
            default: return T3;
        endcase
    endfunction

    task automatic pulse_tick();
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(5);
        check(core_rst == 1'b1, "R1 core_rst in reset", core_rst, 1);
        check(start_done == 1'b0, "R1 start_done in reset", start_done, 0);
        check(power_loss == 1'b0, "R1 power_loss in reset", power_loss, 0);
        rst = 1'b0;
        cyc(1);
        check(vec_load == 1'b0, "R1 vec_load after reset", vec_load, 0);
        check(core_rst == 1'b1, "R1 core_rst after reset", core_rst, 1);
    endtask

    // Hold master clear low, then release it and let the synchroniser settle.
    task automatic mclr_cycle(input string tag);
        mclr_n = 1'b0;
        cyc(5);
        check(core_rst == 1'b1, tag, core_rst, 1);
        mclr_n = 1'b1;
        cyc(6);
    endtask

    // Feed ticks and confirm release on exactly the expected one.
    task automatic count_to_release(input int n, input string tag);
        for (int i = 1; i <= n; i++) begin
            pulse_tick();
            cyc(1);
            if (i < n) begin
                if (i == n - 1)
                    check(core_rst == 1'b1, {tag, " held before last tick"}, core_rst, 1);
            end else begin
                check(start_done == 1'b1, {tag, " released on last tick"}, start_done, 1);
            end
        end
    endtask

    task automatic t_delay(input int osc, input int sel, input string tag);
        int n;
        osc_kind = 2'(osc);
        dly_sel  = 2'(sel);
        n = exp_ticks(osc, sel);
        mclr_cycle("R6 held while mclr_n low");
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1;
            cyc(1);
            tick = 1'b0;
            if (i < n) begin
                cyc(1);
                if (i == n - 1)
                    check(core_rst == 1'b1, {tag, " held before last tick"}, core_rst, 1);
            end else begin
                check(start_done == 1'b1, {tag, " released on last tick"}, start_done, 1);
                check(vec_load == 1'b1, "R9 vec_load with release", vec_load, 1);
                check(vec_addr == {AW{1'b1}}, "R9 vec_addr all ones", vec_addr, 32'h1FF);
                cyc(1);
                check(vec_load == 1'b0, "R9 vec_load single cycle", vec_load, 0);
            end
        end
    endtask

    task automatic t_no_tick();
        osc_kind = 2'd0;
        dly_sel  = 2'd0;
        mclr_cycle("R6 held while mclr_n low");
        cyc(60);
        check(core_rst == 1'b1, "R10 no release without tick", core_rst, 1);
        count_to_release(T0, "R10 then ticks release");
    endtask

    task automatic t_wdog();
        logic plf_before;
        osc_kind = 2'd2;
        dly_sel  = 2'd2;
        plf_before = power_loss;
        check(start_done == 1'b1, "R7 running before watchdog", start_done, 1);
        wdog_expire = 1'b1;
        cyc(1);
        wdog_expire = 1'b0;
        cyc(2);
        check(core_rst == 1'b1, "R7 watchdog holds core", core_rst, 1);
        check(power_loss == plf_before, "R8 watchdog keeps power_loss", power_loss, plf_before);
        cyc(2);
        count_to_release(T2, "R7 full delay after watchdog");
    endtask

    task automatic t_gating();
        logic plf_before;
        // Power-edge detection on: power-on request must be ignored.
        edge_det_en = 1'b1;
        osc_kind = 2'd0;
        dly_sel  = 2'd1;
        plf_before = power_loss;
        pwr_on_req = 1'b1;
        cyc(1);
        pwr_on_req = 1'b0;
        cyc(5);
        check(start_done == 1'b1, "R5 pwr_on ignored with edge_det_en=1", start_done, 1);
        check(power_loss == plf_before, "R5 power_loss untouched", power_loss, plf_before);
        // Power-edge request honoured.
        pwr_edge_req = 1'b1;
        cyc(1);
        pwr_edge_req = 1'b0;
        cyc(3);
        check(core_rst == 1'b1, "R5 pwr_edge honoured", core_rst, 1);
        check(power_loss == 1'b1, "R8 pwr_edge sets power_loss", power_loss, 1);
        cyc(2);
        count_to_release(T1, "R5 delay after pwr_edge");
        // Detection off: power-edge request must be ignored.
        edge_det_en = 1'b0;
        pwr_edge_req = 1'b1;
        cyc(1);
        pwr_edge_req = 1'b0;
        cyc(5);
        check(start_done == 1'b1, "R5 pwr_edge ignored with edge_det_en=0", start_done, 1);
    endtask

    task automatic t_power_flag();
        do_reset();
        osc_kind = 2'd0;
        dly_sel  = 2'd0;
        mclr_cycle("R6 held while mclr_n low");
        check(power_loss == 1'b0, "R8 mclr leaves power_loss clear", power_loss, 0);
        count_to_release(T0, "R8 release after mclr");
        pwr_on_req = 1'b1;
        cyc(1);
        pwr_on_req = 1'b0;
        cyc(4);
        check(power_loss == 1'b1, "R8 pwr_on sets power_loss", power_loss, 1);
        check(core_rst == 1'b1, "R5 pwr_on honoured with edge_det_en=0", core_rst, 1);
        cyc(2);
        count_to_release(T0, "R8 release after pwr_on");
        mclr_cycle("R6 held while mclr_n low");
        check(power_loss == 1'b1, "R8 mclr keeps power_loss set", power_loss, 1);
        count_to_release(T0, "R8 release after second mclr");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(1);
        do_reset();
        // R2: RC takes every code as given
        t_delay(0, 0, "R2 RC code0");
        t_delay(0, 1, "R2 RC code1");
        t_delay(0, 2, "R2 RC code2");
        t_delay(0, 3, "R2 RC code3");
        // R3: fast and standard crystal raise code 0
        t_delay(1, 0, "R3 fast xtal code0");
        t_delay(2, 0, "R3 std xtal code0");
        t_delay(2, 2, "R3 std xtal code2");
        // R4: slow crystal raises codes 0 and 1
        t_delay(3, 0, "R4 slow xtal code0");
        t_delay(3, 1, "R4 slow xtal code1");
        t_delay(3, 3, "R4 slow xtal code3");
        t_no_tick();
        t_wdog();
        t_gating();
        t_power_flag();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule